// File: doc/BRIEF.md
# Sine/Cosine Quadrature Interpolator with Gated Index

This block turns digitized sine and cosine samples from an optical encoder into an interpolated quadrature pair and a phase-aligned index pulse. Each sample is a signed value centred on zero. A bank of comparators with hysteresis resolves the phase of the sample into angular sectors. The active sector is then mapped onto the A/B pair through a Gray sequence, so the pair completes two or four quadrature cycles per input cycle. The x4 select input picks the factor.

The raw index comparator bit is gated by the A/B state. This makes the index output open at a fixed input phase (270 degrees), whatever the factor. The width select input picks a window of one half or one quarter of a quadrature cycle. All outputs are registered and change only on cycles that carry a valid sample. If two consecutive accepted samples are more than one sector apart, the block reports the jump and does not emit an illegal A/B transition.

The input phase is the angle of the point (cos, sin), counted counterclockwise from the positive cos axis. Rising phase is forward motion.

Top module: `sincos_interp`

## Requirements
- R1: With x4_sel_i low, the phase is resolved into 8 sectors of 45 degrees. Sector k spans [45k, 45k+45) degrees. {a_o,b_o} follows the code q = (k+2) mod 4, with q=0 -> 00, q=1 -> 10, q=2 -> 11, q=3 -> 01.
- R2: With x4_sel_i high, the phase is resolved into 16 sectors of 22.5 degrees. Sector k spans [22.5k, 22.5k+22.5) degrees. {a_o,b_o} follows q = k mod 4 with the same code as R1.
- R3: Forward rotation makes A lead B, and reverse rotation makes B lead A. An accepted sample that is not a load (R10) changes at most one of a_o, b_o.
- R4: With z180_sel_i high, z_o equals idx_raw_i AND NOT b_o. It is registered together with the A/B pair it is computed from.
- R5: With z180_sel_i low, z_o equals idx_raw_i AND NOT a_o AND NOT b_o.
- R6: In every combination of factor and width, the index window opens at the sector that starts at 270 degrees.
- R7: Each phase comparator changes state only when its difference is more than HYST LSBs past the boundary. A sample within HYST of a boundary keeps the previous side.
- R8: a_o, b_o, z_o and err_o change only after a clock edge at which valid_i is high.
- R9: A sample whose sector is more than one sector (modulo the sector count) away from the held sector sets err_o. It leaves A/B and the held sector unchanged. err_o holds until the next accepted sample clears it.
- R10: The first valid sample after reset, or the first valid sample after x4_sel_i changes, loads A/B directly from its sector and does not set err_o.
- R11: Reset drives a_o, b_o, z_o and err_o low and clears every comparator state to the negative side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| sin_i | input | W | Signed sine sample |
| cos_i | input | W | Signed cosine sample |
| idx_raw_i | input | 1 | Raw index comparator bit |
| x4_sel_i | input | 1 | 1 = four times interpolation, 0 = two times |
| z180_sel_i | input | 1 | 1 = wide index window, 0 = narrow |
| a_o | output | 1 | Quadrature channel A |
| b_o | output | 1 | Quadrature channel B |
| z_o | output | 1 | Gated index |
| err_o | output | 1 | Sector jump detected |

## Verification
Samples placed at sector centres are applied in forward order through all eight coarse sectors, including the wrap across zero, and then in reverse order. The A/B sequence distinguishes a correct phase origin and lead direction from a mapping that is shifted or mirrored. In four-times mode, the walk around 270 degrees is run with both index widths, which separates gating on B alone from gating on both channels. Directed steps cover a jump of several sectors, a change of mode, samples withheld by the strobe, and samples just inside and just outside the hysteresis band. A reset taken while a comparator sits on its positive side shows whether the hysteresis state is really cleared.

// File: rtl/sci_pkg.sv
package sci_pkg;
  localparam int NCMP  = 6;
  localparam int C_SIN = 0;  // sin > 0
  localparam int C_COS = 1;  // cos > 0
  localparam int C_SUM = 2;  // sin + cos > 0
  localparam int C_DIF = 3;  // cos - sin > 0
  localparam int C_TS  = 4;  // |sin| < t*|cos|
  localparam int C_TC  = 5;  // |cos| > t*|sin|
  localparam int SW    = 4;  // fine sector index width

  typedef logic [1:0] ab_t;  // {A,B}

  function automatic ab_t ab_of(input logic [1:0] q);
    case (q)
      2'd0:    return 2'b00;
      2'd1:    return 2'b10;
      2'd2:    return 2'b11;
      default: return 2'b01;
    endcase
  endfunction
endpackage

// File: rtl/sci_hyst_cmp.sv
module sci_hyst_cmp #(
  parameter int DW   = 15,
  parameter int HYST = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [DW-1:0] diff_i,
  output logic                 nxt_o
);
  localparam logic signed [DW-1:0] HP = DW'(HYST);
  localparam logic signed [DW-1:0] HN = -HP;

  logic st_q;

  always_comb begin
    if (diff_i > HP)      nxt_o = 1'b1;
    else if (diff_i < HN) nxt_o = 1'b0;
    else                  nxt_o = st_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   st_q <= 1'b0;
    else if (en_i) st_q <= nxt_o;
  end
endmodule

// File: rtl/sci_cmp_bank.sv
module sci_cmp_bank
  import sci_pkg::*;
#(
  parameter int W    = 12,
  parameter int HYST = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic signed [W-1:0] sin_i,
  input  logic signed [W-1:0] cos_i,
  output logic [NCMP-1:0]     cmp_o
);
  localparam int DW = W + 3;

  logic signed [DW-1:0] sx, cx, sa, ca, st, ct;
  logic signed [DW-1:0] diff [NCMP];

  always_comb begin
    sx = DW'(sin_i);
    cx = DW'(cos_i);
    sa = (sx < 0) ? -sx : sx;
    ca = (cx < 0) ? -cx : cx;
    // tan(22.5) ~ 0.41406 by shift-add
    st = (sa >>> 2) + (sa >>> 3) + (sa >>> 5) + (sa >>> 7);
    ct = (ca >>> 2) + (ca >>> 3) + (ca >>> 5) + (ca >>> 7);
    diff[C_SIN] = sx;
    diff[C_COS] = cx;
    diff[C_SUM] = sx + cx;
    diff[C_DIF] = cx - sx;
    diff[C_TS]  = ct - sa;
    diff[C_TC]  = ca - st;
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    sci_hyst_cmp #(.DW(DW), .HYST(HYST)) u_cmp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .diff_i (diff[g]),
      .nxt_o  (cmp_o[g])
    );
  end
endmodule

// File: rtl/sci_sector_dec.sv
module sci_sector_dec
  import sci_pkg::*;
(
  input  logic [NCMP-1:0] cmp_i,
  output logic [SW-1:0]   sec_o
);
  logic [2:0] oct;
  logic       fine;

  always_comb begin
    case ({cmp_i[C_SIN], cmp_i[C_COS]})
      2'b11:   oct = cmp_i[C_DIF] ? 3'd0 : 3'd1;
      2'b10:   oct = cmp_i[C_SUM] ? 3'd2 : 3'd3;
      2'b00:   oct = cmp_i[C_DIF] ? 3'd5 : 3'd4;
      default: oct = cmp_i[C_SUM] ? 3'd7 : 3'd6;
    endcase
    case (oct[1:0])
      2'd0:    fine = ~cmp_i[C_TS];
      2'd1:    fine = ~cmp_i[C_TC];
      2'd2:    fine =  cmp_i[C_TC];
      default: fine =  cmp_i[C_TS];
    endcase
    sec_o = {oct, fine};
  end
endmodule

// File: rtl/sci_quad_track.sv
module sci_quad_track
  import sci_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          x4_i,
  input  logic          z180_i,
  input  logic          idx_i,
  input  logic [SW-1:0] sec_i,
  output logic          a_o,
  output logic          b_o,
  output logic          z_o,
  output logic          err_o,
  output logic          load_o
);
  logic [SW-1:0] sec_q, cur, prv, step, msk;
  logic          x4_q, primed_q, ok, accept, z_nx;
  logic [1:0]    qd;
  ab_t           ab_q, ab_new, ab_nx;

  always_comb begin
    msk    = x4_i ? SW'(15) : SW'(7);
    cur    = x4_i ? sec_i : {1'b0, sec_i[SW-1:1]};
    prv    = x4_i ? sec_q : {1'b0, sec_q[SW-1:1]};
    step   = (cur - prv) & msk;
    ok     = (step == '0) || (step == SW'(1)) || (step == msk);
    load_o = !primed_q || (x4_i != x4_q);
    accept = load_o || ok;
    // origin offset puts code 0 at 270 degrees in both modes
    qd     = cur[1:0] + (x4_i ? 2'd0 : 2'd2);
    ab_new = ab_of(qd);
    ab_nx  = accept ? ab_new : ab_q;
    z_nx   = idx_i & (z180_i ? ~ab_nx[0] : (~ab_nx[1] & ~ab_nx[0]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q    <= '0;
      x4_q     <= 1'b0;
      primed_q <= 1'b0;
      ab_q     <= 2'b00;
      z_o      <= 1'b0;
      err_o    <= 1'b0;
    end else if (valid_i) begin
      primed_q <= 1'b1;
      x4_q     <= x4_i;
      ab_q     <= ab_nx;
      z_o      <= z_nx;
      err_o    <= ~accept;
      if (accept) sec_q <= sec_i;
    end
  end

  assign a_o = ab_q[1];
  assign b_o = ab_q[0];
endmodule

// File: rtl/sincos_interp.sv
module sincos_interp
  import sci_pkg::*;
#(
  parameter int W    = 12,
  parameter int HYST = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic signed [W-1:0] sin_i,
  input  logic signed [W-1:0] cos_i,
  input  logic                idx_raw_i,
  input  logic                x4_sel_i,
  input  logic                z180_sel_i,
  output logic                a_o,
  output logic                b_o,
  output logic                z_o,
  output logic                err_o
);
  logic [NCMP-1:0] cmp;
  logic [SW-1:0]   sec;
  logic            load;

  sci_cmp_bank #(.W(W), .HYST(HYST)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (valid_i),
    .sin_i  (sin_i),
    .cos_i  (cos_i),
    .cmp_o  (cmp)
  );

  sci_sector_dec u_dec (
    .cmp_i (cmp),
    .sec_o (sec)
  );

  sci_quad_track u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .x4_i    (x4_sel_i),
    .z180_i  (z180_sel_i),
    .idx_i   (idx_raw_i),
    .sec_i   (sec),
    .a_o     (a_o),
    .b_o     (b_o),
    .z_o     (z_o),
    .err_o   (err_o),
    .load_o  (load)
  );
endmodule

// File: rtl/sincos_interp_chk.sv
module sincos_interp_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic idx_raw_i,
  input logic z180_sel_i,
  input logic a_o,
  input logic b_o,
  input logic z_o,
  input logic err_o,
  input logic load_i
);
  assert_one_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !load_i |=> $countones({a_o, b_o} ^ $past({a_o, b_o})) <= 1);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable({a_o, b_o, z_o, err_o}));

  assert_wide_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_o |-> !b_o);

  assert_raw_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !idx_raw_i |=> !z_o);

  assert_narrow_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !z180_sel_i |=> !z_o || (!a_o && !b_o));

  assert_err_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $stable({a_o, b_o}));

  assert_load_no_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && load_i |=> !err_o);
endmodule

bind sincos_interp sincos_interp_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .idx_raw_i  (idx_raw_i),
  .z180_sel_i (z180_sel_i),
  .a_o        (a_o),
  .b_o        (b_o),
  .z_o        (z_o),
  .err_o      (err_o),
  .load_i     (load)
);

// File: tb/sincos_interp_tb.sv
`timescale 1ns/1ps
module sincos_interp_tb;
  localparam int W = 12;

  typedef struct packed {
    logic x4;
    logic z180;
    logic idx;
    int   ang;   // degrees * 100
    logic a;
    logic b;
    logic z;
    logic err;
  } vec_t;

  // 2x: k -> AB 11,01,00,10 repeating from k=0 ; 4x: k -> 00,10,11,01
  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0, 2250, 1'b1,1'b1,1'b0,1'b0}, // R1 load s0
    '{1'b0,1'b1,1'b0, 6750, 1'b0,1'b1,1'b0,1'b0}, // R1/R3 s1
    '{1'b0,1'b1,1'b0,11250, 1'b0,1'b0,1'b0,1'b0}, // s2
    '{1'b0,1'b1,1'b0,15750, 1'b1,1'b0,1'b0,1'b0}, // s3
    '{1'b0,1'b1,1'b0,20250, 1'b1,1'b1,1'b0,1'b0}, // s4
    '{1'b0,1'b1,1'b1,24750, 1'b0,1'b1,1'b0,1'b0}, // R4 B high blocks
    '{1'b0,1'b1,1'b1,29250, 1'b0,1'b0,1'b1,1'b0}, // R6 opens at 270
    '{1'b0,1'b1,1'b1,33750, 1'b1,1'b0,1'b1,1'b0}, // R4 wide window
    '{1'b0,1'b1,1'b1, 2250, 1'b1,1'b1,1'b0,1'b0}, // wrap forward
    '{1'b0,1'b1,1'b0,33750, 1'b1,1'b0,1'b0,1'b0}, // R3 reverse wrap
    '{1'b0,1'b0,1'b1,29250, 1'b0,1'b0,1'b1,1'b0}, // R5 narrow open
    '{1'b0,1'b0,1'b1,33750, 1'b1,1'b0,1'b0,1'b0}, // R5 A high blocks
    '{1'b1,1'b0,1'b0, 1125, 1'b0,1'b0,1'b0,1'b0}, // R10 mode change load
    '{1'b1,1'b0,1'b0, 3375, 1'b1,1'b0,1'b0,1'b0}, // R2 s1
    '{1'b1,1'b0,1'b0, 5625, 1'b1,1'b1,1'b0,1'b0}, // R2 s2
    '{1'b1,1'b0,1'b0, 7875, 1'b0,1'b1,1'b0,1'b0}, // R2 s3
    '{1'b1,1'b0,1'b0,10125, 1'b0,1'b0,1'b0,1'b0}, // R2 s4
    '{1'b1,1'b0,1'b0,28125, 1'b0,1'b0,1'b0,1'b1}, // R9 jump held
    '{1'b1,1'b0,1'b0,12375, 1'b1,1'b0,1'b0,1'b0}, // R9 recovery s5
    '{1'b0,1'b1,1'b0,24750, 1'b0,1'b1,1'b0,1'b0}, // R10 load 2x s5
    '{1'b1,1'b1,1'b0,25875, 1'b0,1'b1,1'b0,1'b0}, // R10 load 4x s11
    '{1'b1,1'b1,1'b1,28125, 1'b0,1'b0,1'b1,1'b0}, // R6 4x wide open
    '{1'b1,1'b1,1'b1,30375, 1'b1,1'b0,1'b1,1'b0}, // R4 4x s13
    '{1'b1,1'b1,1'b1,32625, 1'b1,1'b1,1'b0,1'b0}, // R4 4x s14 closed
    '{1'b1,1'b0,1'b1,30375, 1'b1,1'b0,1'b0,1'b0}, // R5 4x s13 closed
    '{1'b1,1'b0,1'b1,28125, 1'b0,1'b0,1'b1,1'b0}  // R6 4x narrow open
  };

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic                valid = 1'b0;
  logic signed [W-1:0] sin_v = '0;
  logic signed [W-1:0] cos_v = '0;
  logic                idx = 1'b0;
  logic                x4 = 1'b0;
  logic                z180 = 1'b0;
  logic                a, b, z, err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  sincos_interp #(.W(W), .HYST(8)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .valid_i    (valid),
    .sin_i      (sin_v),
    .cos_i      (cos_v),
    .idx_raw_i  (idx),
    .x4_sel_i   (x4),
    .z180_sel_i (z180),
    .a_o        (a),
    .b_o        (b),
    .z_o        (z),
    .err_o      (err)
  );

  task automatic check(input string req, input logic [3:0] exp);
    n_chk++;
    if ({a, b, z, err} !== exp) begin
      n_bad++;
      $display("FAIL %s: {a,b,z,err} got %b expected %b", req, {a, b, z, err}, exp);
    end
  endtask

  task automatic put(input logic m4, input logic zs, input logic ix,
                     input int s, input int c, input logic v);
    @(negedge clk);
    x4 = m4; z180 = zs; idx = ix;
    sin_v = W'(s); cos_v = W'(c); valid = v;
    @(negedge clk);
    valid = 1'b0;
  endtask

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  task automatic put_ang(input logic m4, input logic zs, input logic ix, input int ang);
    real th;
    th = ang * 3.14159265358979 / 18000.0;
    put(m4, zs, ix, rnd(1000.0 * $sin(th)), rnd(1000.0 * $cos(th)), 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset state", 4'b0000);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      put_ang(VEC[i].x4, VEC[i].z180, VEC[i].idx, VEC[i].ang);
      check($sformatf("R1/R2/R3 vector %0d", i),
            {VEC[i].a, VEC[i].b, VEC[i].z, VEC[i].err});
    end

    // R8: new inputs without strobe leave outputs as they were (0,0,1,0)
    put(1'b1, 1'b1, 1'b0, 700, 700, 1'b0);
    check("R8 no strobe", 4'b0010);

    // sin comparator driven positive, then reset must clear it (R11)
    put(1'b0, 1'b1, 1'b0, 100, 1000, 1'b1);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    check("R11 reset mid-run", 4'b0000);
    rst_ni = 1'b1;
    // sin=+5 is inside the band: cleared state keeps sector 7 -> AB 10
    put(1'b0, 1'b1, 1'b0, 5, 1000, 1'b1);
    check("R11 hysteresis cleared", 4'b1000);

    // R7 band tests in 2x around zero phase
    put(1'b0, 1'b1, 1'b0, 100, 1000, 1'b1);
    check("R7 beyond band to s0", 4'b1100);
    put(1'b0, 1'b1, 1'b0, -5, 1000, 1'b1);
    check("R7 inside band holds s0", 4'b1100);
    put(1'b0, 1'b1, 1'b0, -20, 1000, 1'b1);
    check("R7 beyond band to s7", 4'b1000);
    put(1'b0, 1'b1, 1'b0, 5, 1000, 1'b1);
    check("R7 inside band holds s7", 4'b1000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule